// File: doc/BRIEF.md
# MDIO Register Access Controller

This block lets a processor run single clause-22 management transactions to an external PHY through one 32-bit register. Software writes a command word holding write data, a PHY address, a register address and a two-bit opcode. The controller then divides the system clock down to a management clock, shifts a complete frame out on the management data pin, and, for reads, releases the pin at turnaround and shifts the PHY's answer back in. While a frame runs a busy flag reads as one. When a read ends, the captured data word and a not-valid flag (set when no PHY drove the second turnaround bit low) appear in the same register that took the command.

Every frame carries 32 preamble ones, the start pattern 01, the opcode (10 read, 01 write), the 5-bit PHY address, the 5-bit register address, two turnaround bits (10 on a write, released on a read) and 16 data bits, most significant first. The outgoing data line changes only just after a management clock falling edge. Incoming data is sampled on the rising edge. The command side is a plain write strobe with no back-pressure: the register takes a word only when idle, and a word written while busy is dropped. Software is expected to poll the busy flag before writing.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the register reads back data 0, PHY address equal to the parameter PHY_ADDR_RST in bits 15:11, register address 0 in bits 10:6, busy (bit 3) 0 and not-valid (bit 4) 0, with all other bits zero. The management clock is low and the data pin is released.
- R2: An accepted command word loads write data from bits 31:16, PHY address from bits 15:11 and register address from bits 10:6. Bit 0 starts a write and bit 1 starts a read. When both bits are set, the command is a read.
- R3: Busy (bit 3) reads 1 from the clock after a command with an opcode is accepted. It stays 1 for exactly 128*MDC_HALF system clocks, which is 64 management clock periods.
- R4: The management clock has a period of 2*MDC_HALF system clocks while a frame runs, and it is held low when idle.
- R5: A write frame consists of 32 ones, 01, opcode 01, PHY address, register address, turnaround 10 and the 16 write data bits, each field sent most significant bit first.
- R6: A read frame sends opcode 10 and releases the data pin from the first turnaround bit until the end of the frame. It samples 16 data bits on the rising edges, places them in bits 31:16 at the end of the frame, and clears not-valid.
- R7: If the line is not low when the second read turnaround bit is sampled, not-valid (bit 4) is set at the end of the read. Any later accepted command with an opcode clears it.
- R8: A command written while busy is 1 is ignored. The running frame and the stored fields are unchanged.
- R9: A command word with both opcode bits clear updates the data, PHY address and register address fields. It starts no frame and leaves busy at 0.
- R10: The outgoing data pin changes only together with a falling edge of the management clock while a frame runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word |
| reg_rdata | output | 32 | Register readback: data, addresses, not-valid, busy |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable (1 = drive) |
| mdio_i | input | 1 | Management data in, from the pad |

## Verification
On every cycle the assertions check the following: busy rises on an accepted command, frame length in system clocks, the idle-low clock, release of the data pin when idle, the data pin changing only with a clock fall, a dropped command leaving the fields untouched, and a no-opcode word leaving the block idle. Only the bench scenarios can show what the frame carries bit by bit, which requires a PHY model decoding the serial stream. The same holds for the read data that lands in the register, the not-valid outcome with and without a responding PHY, and the clock period.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 4 + 2*ADDR_W + 2 + DATA_W;
  localparam int TA_IDX     = PRE_BITS + 4 + 2*ADDR_W;
  localparam int DATA_IDX   = TA_IDX + 2;
  localparam int BUSY_BIT   = 3;
  localparam int NVALID_BIT = 4;
  localparam int FLD_DATA_LSB = 16;
  localparam int FLD_PHY_LSB  = 11;
  localparam int FLD_REG_LSB  = 6;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int MDC_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (MDC_HALF < 2) ? 1 : $clog2(MDC_HALF);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = (cnt == CW'(MDC_HALF - 1));
  assign rise_tick = run && wrap && !mdc;
  assign fall_tick = run && wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_framer.sv
module mdio_framer
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_op_e          start_op,
  input  logic [ADDR_W-1:0] start_phy,
  input  logic [ADDR_W-1:0] start_reg,
  input  logic [DATA_W-1:0] start_data,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ta_bad
);
  localparam int BCW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [BCW-1:0]        bitcnt;
  logic                  active;
  logic                  is_read;
  logic [1:0]            op_bits;
  logic [1:0]            ta_bits;
  logic                  last_bit;
  logic                  released;

  always_comb begin
    op_bits = (start_op == OP_READ) ? 2'b10 : 2'b01;
    ta_bits = (start_op == OP_READ) ? 2'b11 : 2'b10;
  end

  assign last_bit = (bitcnt == BCW'(FRAME_BITS - 1));
  assign released = is_read && (bitcnt >= BCW'(TA_IDX));
  assign done     = active && fall_tick && last_bit;
  assign mdio_o   = shreg[FRAME_BITS-1];
  assign mdio_oe  = active && !released;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '1;
      bitcnt  <= '0;
      active  <= 1'b0;
      is_read <= 1'b0;
      rd_data <= '0;
      ta_bad  <= 1'b0;
    end else if (start) begin
      shreg   <= {{PRE_BITS{1'b1}}, 2'b01, op_bits, start_phy, start_reg,
                  ta_bits, start_data};
      bitcnt  <= '0;
      active  <= 1'b1;
      is_read <= (start_op == OP_READ);
      ta_bad  <= 1'b0;
    end else if (active) begin
      if (rise_tick && is_read) begin
        if (bitcnt == BCW'(TA_IDX + 1))
          ta_bad <= mdio_i;
        if (bitcnt >= BCW'(DATA_IDX))
          rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      end
      if (fall_tick) begin
        if (last_bit) begin
          active <= 1'b0;
        end else begin
          shreg  <= {shreg[FRAME_BITS-2:0], 1'b1};
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PHY_ADDR_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [31:0]       cmd_wdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              ta_bad,
  output logic              start,
  output mdio_op_e          start_op,
  output logic [31:0]       reg_rdata
);
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] phy_q;
  logic [ADDR_W-1:0] reg_q;
  logic              busy_q;
  logic              nvalid_q;
  logic              cur_read_q;
  logic              take;

  always_comb begin
    if (cmd_wdata[1])      start_op = OP_READ;
    else if (cmd_wdata[0]) start_op = OP_WRITE;
    else                   start_op = OP_NONE;
  end

  assign take  = cmd_we && !busy_q;
  assign start = take && (start_op != OP_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q     <= '0;
      phy_q      <= PHY_ADDR_RST;
      reg_q      <= '0;
      busy_q     <= 1'b0;
      nvalid_q   <= 1'b0;
      cur_read_q <= 1'b0;
    end else if (take) begin
      data_q <= cmd_wdata[FLD_DATA_LSB +: DATA_W];
      phy_q  <= cmd_wdata[FLD_PHY_LSB +: ADDR_W];
      reg_q  <= cmd_wdata[FLD_REG_LSB +: ADDR_W];
      if (start_op != OP_NONE) begin
        busy_q     <= 1'b1;
        nvalid_q   <= 1'b0;
        cur_read_q <= (start_op == OP_READ);
      end
    end else if (done) begin
      busy_q <= 1'b0;
      if (cur_read_q) begin
        data_q   <= rd_data;
        nvalid_q <= ta_bad;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[FLD_DATA_LSB +: DATA_W] = data_q;
    reg_rdata[FLD_PHY_LSB +: ADDR_W]  = phy_q;
    reg_rdata[FLD_REG_LSB +: ADDR_W]  = reg_q;
    reg_rdata[NVALID_BIT]             = nvalid_q;
    reg_rdata[BUSY_BIT]               = busy_q;
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int                MDC_HALF     = 2,
  parameter logic [ADDR_W-1:0] PHY_ADDR_RST = 5'd3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              start;
  mdio_op_e          start_op;
  logic              rise_tick;
  logic              fall_tick;
  logic              done;
  logic [DATA_W-1:0] rd_data;
  logic              ta_bad;

  mdio_cmd_reg #(.PHY_ADDR_RST(PHY_ADDR_RST)) u_reg (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .done(done), .rd_data(rd_data), .ta_bad(ta_bad),
    .start(start), .start_op(start_op), .reg_rdata(reg_rdata)
  );

  mdio_clkgen #(.MDC_HALF(MDC_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(reg_rdata[BUSY_BIT]),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_framer u_frm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
    .start_phy(cmd_wdata[FLD_PHY_LSB +: ADDR_W]),
    .start_reg(cmd_wdata[FLD_REG_LSB +: ADDR_W]),
    .start_data(cmd_wdata[FLD_DATA_LSB +: DATA_W]),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
    .rd_data(rd_data), .ta_bad(ta_bad)
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [31:0] cmd_wdata,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  localparam int FRAME_CYC = FRAME_BITS * 2 * MDC_HALF;

  logic        busy;
  logic [31:0] bcnt;

  assign busy = reg_rdata[BUSY_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) bcnt <= '0;
    else                 bcnt <= bcnt + 1'b1;
  end

  a_r3_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy && (cmd_wdata[1:0] != 2'b00)) |=> busy);

  a_r3_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == FRAME_CYC));

  a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && busy) |=> $stable(reg_rdata[15:6]));

  a_r9_noop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy && (cmd_wdata[1:0] == 2'b00)) |=> !busy);

  a_r10_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.MDC_HALF(MDC_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
  localparam int       HALF    = 2;
  localparam logic [4:0] RSTPHY = 5'd3;
  localparam int       FCYC    = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl #(.MDC_HALF(HALF), .PHY_ADDR_RST(RSTPHY)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // PHY model with pull-up on the shared line
  logic        phy_oe = 1'b0;
  logic        phy_o = 1'b1;
  logic [63:0] cap = '0;
  logic [15:0] resp = '0;
  logic        held = 1'b1;
  int          pcnt = 0;
  int          viol = 0;
  int          cyc = 0;
  int          rises = 0;
  wire         line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);
  assign mdio_i = line;

  function automatic logic [15:0] phy_reply(input logic [4:0] ra);
    return 16'hA5C3 ^ {11'd0, ra};
  endfunction

  always @(posedge clk) cyc = cyc + 1;

  always @(posedge mdc) begin
    if (pcnt < 64) cap[63-pcnt] = line;
    held  = line;
    pcnt  = pcnt + 1;
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    if (pcnt == 47 && cap[29:28] == 2'b10 && cap[27:23] == RSTPHY) begin
      resp   = phy_reply(cap[22:18]);
      phy_oe = 1'b1;
      phy_o  = 1'b0;
    end else if (phy_oe && pcnt >= 48 && pcnt <= 63) begin
      phy_o = resp[63-pcnt];
    end else if (pcnt >= 64) begin
      phy_oe = 1'b0;
    end
  end

  always @(negedge clk) if (mdc && line !== held) viol = viol + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (reg_rdata[3] && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] word(input logic [15:0] d, input logic [4:0] p,
                                       input logic [4:0] r, input logic [1:0] op);
    return {d, p, r, 4'b0000, op};
  endfunction

  task automatic t_reset;
    chk("R1 readback", reg_rdata, {16'h0, RSTPHY, 11'h0});
    chk("R1 mdc low", mdc, 0);
    chk("R1 released", mdio_oe, 0);
  endtask

  task automatic t_write;
    int n;
    pcnt = 0; viol = 0;
    send(word(16'hBEEF, RSTPHY, 5'd9, 2'b01));
    chk("R3 busy after accept", reg_rdata[3], 1);
    wait_idle(n);
    chk("R3 busy length", n, FCYC);
    chk("R5 preamble", cap[63:32], 32'hFFFF_FFFF);
    chk("R5 start+op", cap[31:28], 4'b0101);
    chk("R5 phy addr", cap[27:23], RSTPHY);
    chk("R5 reg addr", cap[22:18], 5'd9);
    chk("R5 turnaround", cap[17:16], 2'b10);
    chk("R5 data", cap[15:0], 16'hBEEF);
    chk("R5 bit count", pcnt, 64);
    chk("R2 readback fields", reg_rdata, word(16'hBEEF, RSTPHY, 5'd9, 2'b00));
    chk("R10 no change while mdc high", viol, 0);
    chk("R1 released after frame", mdio_oe, 0);
  endtask

  task automatic t_period;
    int n, c0;
    send(word(16'h0001, RSTPHY, 5'd1, 2'b01));
    @(posedge mdc); c0 = cyc;
    @(posedge mdc);
    chk("R4 mdc period", cyc - c0, 2 * HALF);
    wait_idle(n);
    repeat (3) @(negedge clk);
    chk("R4 mdc idle low", mdc, 0);
  endtask

  task automatic t_read_ok;
    int n;
    pcnt = 0; viol = 0;
    send(word(16'h0000, RSTPHY, 5'd6, 2'b10));
    wait_idle(n);
    chk("R6 opcode", cap[29:28], 2'b10);
    chk("R6 ta first released", cap[17], 1);
    chk("R6 ta second low", cap[16], 0);
    chk("R6 read data", reg_rdata[31:16], phy_reply(5'd6));
    chk("R6 nvalid clear", reg_rdata[4], 0);
    chk("R10 read frame", viol, 0);
  endtask

  task automatic t_read_none;
    int n;
    pcnt = 0;
    send(word(16'h1234, 5'd7, 5'd2, 2'b10));
    wait_idle(n);
    chk("R7 nvalid set", reg_rdata[4], 1);
    chk("R7 data pulled high", reg_rdata[31:16], 16'hFFFF);
    send(word(16'h0055, RSTPHY, 5'd2, 2'b01));
    wait_idle(n);
    chk("R7 nvalid cleared by write", reg_rdata[4], 0);
  endtask

  task automatic t_busy_ignore;
    int n;
    pcnt = 0;
    send(word(16'h1234, RSTPHY, 5'd2, 2'b01));
    repeat (10) @(negedge clk);
    send(word(16'h9999, 5'd5, 5'd1, 2'b10));
    chk("R8 fields kept", reg_rdata[15:6], {RSTPHY, 5'd2});
    wait_idle(n);
    repeat (2 * HALF + 2) @(negedge clk);
    chk("R8 frame op", cap[29:28], 2'b01);
    chk("R8 frame reg", cap[22:18], 5'd2);
    chk("R8 frame data", cap[15:0], 16'h1234);
    chk("R8 single frame", pcnt, 64);
    chk("R8 data kept", reg_rdata[31:16], 16'h1234);
  endtask

  task automatic t_noop;
    int r0;
    r0 = rises;
    send(word(16'h7777, 5'd12, 5'd4, 2'b00));
    chk("R9 busy stays 0", reg_rdata[3], 0);
    chk("R9 fields", reg_rdata, word(16'h7777, 5'd12, 5'd4, 2'b00));
    repeat (20) @(negedge clk);
    chk("R9 no clock", rises - r0, 0);
  endtask

  task automatic t_both;
    int n;
    pcnt = 0;
    send(word(16'hAAAA, RSTPHY, 5'd5, 2'b11));
    wait_idle(n);
    chk("R2 both bits read", cap[29:28], 2'b10);
    chk("R2 both bits data", reg_rdata[31:16], phy_reply(5'd5));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_period();
    t_read_ok();
    t_read_none();
    t_busy_ignore();
    t_noop();
    t_both();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule